// File: doc/BRIEF.md
# Transceiver Reset and Power-Mode Sequencer

This block sits beside an Ethernet transceiver core and decides when that core is held in reset and when it runs in a low-power state. Three sources can reset it. The first is an internal power-on pulse. The second is an asynchronous active-low board pin, which only counts once it has been held low for a qualifying time. The third is a self-clearing command bit written through a small management register port. The two reset kinds treat the configuration strap pins differently. A pin or power-on reset samples the straps again. A command reset restores the registers to their defaults and leaves the latched straps as they were.

A command reset holds the core in reset for a fixed time. A further hold-off window follows it. During the whole interval a busy flag is raised, management writes are discarded and reads return zero. The block has two low-power controls. One is a forced power-down bit in the basic control register. The other is an energy-detect mode in a second register: with no line activity the core sleeps, and activity wakes it until the line has been quiet for a while. While energy-detect is on, a periodic one-cycle wake strobe goes to the transmitter whatever the line state.

Top module: `phy_rst_ctrl`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is high, the basic register resets to `BASIC_DEFAULT` (0x3100 by default), the energy register resets to 0, and `strap_o` takes `strap_i`.
- R2: A low pulse on `hw_rst_n_i` shorter than `HW_MIN_CYC` cycles (allowing two synchroniser cycles) has no effect: `core_rst_o` stays low, and the registers and `strap_o` keep their values.
- R3: Holding `hw_rst_n_i` low for at least `HW_MIN_CYC` cycles raises `core_rst_o` and returns both registers to their defaults. `strap_o` keeps following `strap_i` until the pin is released.
- R4: Writing address 0x00 with bit 15 set while not busy raises `mgmt_busy_o` for exactly `SW_RST_CYC + HOLD_CYC` cycles. During the first `SW_RST_CYC` of these cycles `core_rst_o` is high.
- R5: A command reset returns both registers to their defaults and leaves `strap_o` unchanged. `strap_o` never changes while `core_rst_o` is low.
- R6: While `mgmt_busy_o` is high, writes are dropped and `mgmt_rdata_o` is zero.
- R7: Bit 15 of address 0x00 clears itself: once the reset completes it reads 0.
- R8: Bit 11 of address 0x00 set drives `pwr_down_o` high.
- R9: Bit 0 of address 0x1D enables energy-detect. When it is enabled and the line is idle, `pwr_down_o` is high. A cycle of `line_act_i` drives it low from the next cycle, and it stays low until `QUIET_CYC` cycles pass with no activity.
- R10: While energy-detect is enabled, `tx_wake_o` pulses for one cycle every `WAKE_CYC` cycles, regardless of `line_act_i`. While it is disabled, there are no pulses.
- R11: Addresses other than 0x00 and 0x1D read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Internal power-on reset pulse, active high, synchronous |
| hw_rst_n_i | input | 1 | Board reset pin, active low, asynchronous |
| strap_i | input | STRAP_W | Configuration strap pins |
| line_act_i | input | 1 | Line activity indication |
| mgmt_we_i | input | 1 | Management write strobe |
| mgmt_addr_i | input | 5 | Management register address |
| mgmt_wdata_i | input | 16 | Management write data |
| mgmt_rdata_o | output | 16 | Management read data (combinational from address) |
| core_rst_o | output | 1 | Reset to transceiver core |
| strap_o | output | STRAP_W | Latched strap configuration |
| pwr_down_o | output | 1 | Low-power enable to core |
| tx_wake_o | output | 1 | Periodic transmitter wake strobe |
| mgmt_busy_o | output | 1 | Reset and hold-off in progress |

## Verification
The bench shrinks every duration to a few cycles: a 6-cycle pin qualification, a 5-cycle command reset, a 7-cycle hold-off, a 10-cycle quiet timeout and a 16-cycle wake period. With these values, the exact busy and core-reset lengths can be counted cycle by cycle. A 2-cycle pin glitch can be set against a 12-cycle qualifying pulse. Several wake intervals, and the return to sleep after line activity, also fit into a short run.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] ADDR_BASIC = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_EDET  = 5'h1D;

    localparam int BIT_SWRST = 15;
    localparam int BIT_PDOWN = 11;
    localparam int BIT_EDEN  = 0;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RESET,
        SEQ_HOLD
    } seq_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mgmt_req_t;

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return (a == ADDR_BASIC) || (a == ADDR_EDET);
    endfunction

    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/phy_rst_pulse_qual.sv
module phy_rst_pulse_qual #(
    parameter int MIN_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic qual
);
    localparam int CW = phy_rst_pkg::cnt_width(MIN_CYC);

    logic          sync1_q, sync2_q;
    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q   <= 1'b1;
            sync2_q   <= 1'b1;
            low_cnt_q <= '0;
            qual      <= 1'b0;
        end else begin
            sync1_q <= pin_n;
            sync2_q <= sync1_q;
            if (sync2_q) begin
                low_cnt_q <= '0;
                qual      <= 1'b0;
            end else begin
                if (low_cnt_q != CW'(MIN_CYC))
                    low_cnt_q <= low_cnt_q + 1'b1;
                qual <= (low_cnt_q >= CW'(MIN_CYC - 1));
            end
        end
    end
endmodule

// File: rtl/phy_rst_swseq.sv
module phy_rst_swseq
    import phy_rst_pkg::*;
#(
    parameter int RST_CYC  = 250,
    parameter int HOLD_CYC = 750
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic in_reset
);
    localparam int MAXC = (RST_CYC > HOLD_CYC) ? RST_CYC : HOLD_CYC;
    localparam int CW   = cnt_width(MAXC);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start) begin
                    state_q <= SEQ_RESET;
                    cnt_q   <= '0;
                end
                SEQ_RESET: if (cnt_q == CW'(RST_CYC - 1)) begin
                    state_q <= SEQ_HOLD;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                SEQ_HOLD: if (cnt_q == CW'(HOLD_CYC - 1)) begin
                    state_q <= SEQ_IDLE;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != SEQ_IDLE);
    assign in_reset = (state_q == SEQ_RESET);
endmodule

// File: rtl/phy_rst_energy.sv
module phy_rst_energy #(
    parameter int QUIET_CYC = 1024,
    parameter int WAKE_CYC  = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic line_act,
    output logic sleep,
    output logic wake
);
    localparam int QW = phy_rst_pkg::cnt_width(QUIET_CYC);
    localparam int WW = phy_rst_pkg::cnt_width(WAKE_CYC);

    logic          awake_q;
    logic [QW-1:0] quiet_q;
    logic [WW-1:0] wcnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            awake_q <= 1'b0;
            quiet_q <= '0;
            wcnt_q  <= '0;
            wake    <= 1'b0;
        end else begin
            if (line_act) begin
                awake_q <= 1'b1;
                quiet_q <= '0;
            end else if (awake_q) begin
                if (quiet_q == QW'(QUIET_CYC - 1)) begin
                    awake_q <= 1'b0;
                    quiet_q <= '0;
                end else begin
                    quiet_q <= quiet_q + 1'b1;
                end
            end
            if (wcnt_q == WW'(WAKE_CYC - 1)) begin
                wcnt_q <= '0;
                wake   <= 1'b1;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
                wake   <= 1'b0;
            end
        end
    end

    assign sleep = en && !awake_q;
endmodule

// File: rtl/phy_rst_ctrl.sv
module phy_rst_ctrl
    import phy_rst_pkg::*;
#(
    parameter int          STRAP_W       = 8,
    parameter int          HW_MIN_CYC    = 250,
    parameter int          SW_RST_CYC    = 250,
    parameter int          HOLD_CYC      = 750,
    parameter int          QUIET_CYC     = 1024,
    parameter int          WAKE_CYC      = 4096,
    parameter logic [15:0] BASIC_DEFAULT = 16'h3100
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               hw_rst_n_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               line_act_i,
    input  logic               mgmt_we_i,
    input  logic [4:0]         mgmt_addr_i,
    input  logic [15:0]        mgmt_wdata_i,
    output logic [15:0]        mgmt_rdata_o,
    output logic               core_rst_o,
    output logic [STRAP_W-1:0] strap_o,
    output logic               pwr_down_o,
    output logic               tx_wake_o,
    output logic               mgmt_busy_o
);
    localparam logic [DATA_W-1:0] SELF_CLR_MASK = DATA_W'(1) << BIT_SWRST;

    mgmt_req_t          req;
    logic               hw_qual, seq_reset, seq_busy, ed_sleep;
    logic               hard_rst, wr_ok, sw_start, reg_clr;
    logic [DATA_W-1:0]  basic_q, edet_q;
    logic [STRAP_W-1:0] strap_q;

    assign req      = '{we: mgmt_we_i, addr: mgmt_addr_i, wdata: mgmt_wdata_i};
    assign hard_rst = por_i || hw_qual;
    assign wr_ok    = req.we && !seq_busy;
    assign sw_start = wr_ok && (req.addr == ADDR_BASIC) && req.wdata[BIT_SWRST];
    assign reg_clr  = hard_rst || sw_start;

    phy_rst_pulse_qual #(.MIN_CYC(HW_MIN_CYC)) u_qual (
        .clk   (clk),
        .rst   (por_i),
        .pin_n (hw_rst_n_i),
        .qual  (hw_qual)
    );

    phy_rst_swseq #(.RST_CYC(SW_RST_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk      (clk),
        .rst      (hard_rst),
        .start    (sw_start),
        .busy     (seq_busy),
        .in_reset (seq_reset)
    );

    phy_rst_energy #(.QUIET_CYC(QUIET_CYC), .WAKE_CYC(WAKE_CYC)) u_energy (
        .clk      (clk),
        .rst      (hard_rst),
        .en       (edet_q[BIT_EDEN]),
        .line_act (line_act_i),
        .sleep    (ed_sleep),
        .wake     (tx_wake_o)
    );

    always_ff @(posedge clk) begin
        if (reg_clr) begin
            basic_q <= BASIC_DEFAULT & ~SELF_CLR_MASK;
            edet_q  <= '0;
        end else if (wr_ok) begin
            if (req.addr == ADDR_BASIC) basic_q <= req.wdata & ~SELF_CLR_MASK;
            if (req.addr == ADDR_EDET)  edet_q  <= req.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (hard_rst) strap_q <= strap_i;
    end

    always_comb begin
        mgmt_rdata_o = '0;
        if (!seq_busy) begin
            unique case (1'b1)
                (req.addr == ADDR_BASIC): mgmt_rdata_o = basic_q;
                (req.addr == ADDR_EDET):  mgmt_rdata_o = edet_q;
                default:                  mgmt_rdata_o = '0;
            endcase
        end
    end

    assign core_rst_o  = hard_rst || seq_reset;
    assign strap_o     = strap_q;
    assign pwr_down_o  = basic_q[BIT_PDOWN] || ed_sleep;
    assign mgmt_busy_o = seq_busy;
endmodule

// File: rtl/phy_rst_ctrl_chk.sv
module phy_rst_ctrl_chk #(
    parameter int STRAP_W = 8
) (
    input logic               clk,
    input logic               por_i,
    input logic               mgmt_we_i,
    input logic [4:0]         mgmt_addr_i,
    input logic [15:0]        mgmt_wdata_i,
    input logic [15:0]        mgmt_rdata_o,
    input logic               core_rst_o,
    input logic [STRAP_W-1:0] strap_o,
    input logic               pwr_down_o,
    input logic               tx_wake_o,
    input logic               mgmt_busy_o
);
    p_por_core_r1: assert property (@(posedge clk)
        por_i |-> core_rst_o);

    p_swrst_begin_r4: assert property (@(posedge clk) disable iff (por_i)
        (mgmt_we_i && !mgmt_busy_o && mgmt_addr_i == 5'h00 && mgmt_wdata_i[15])
        |=> (mgmt_busy_o && core_rst_o));

    p_strap_keep_r5: assert property (@(posedge clk) disable iff (por_i)
        !core_rst_o |=> $stable(strap_o));

    p_busy_rd_zero_r6: assert property (@(posedge clk) disable iff (por_i)
        mgmt_busy_o |-> (mgmt_rdata_o == 16'h0000));

    p_pdown_bit_r8: assert property (@(posedge clk) disable iff (por_i)
        (!mgmt_busy_o && mgmt_addr_i == 5'h00 && mgmt_rdata_o[11]) |-> pwr_down_o);

    p_wake_single_r10: assert property (@(posedge clk) disable iff (por_i)
        tx_wake_o |=> !tx_wake_o);

    p_unmapped_r11: assert property (@(posedge clk) disable iff (por_i)
        (mgmt_addr_i != 5'h00 && mgmt_addr_i != 5'h1D) |-> (mgmt_rdata_o == 16'h0000));
endmodule

bind phy_rst_ctrl phy_rst_ctrl_chk #(.STRAP_W(STRAP_W)) u_chk (.*);

// File: tb/phy_rst_ctrl_tb.sv
module phy_rst_ctrl_tb;
    localparam int STRAP_W = 8;
    localparam int HW_MIN  = 6;
    localparam int SW_RST  = 5;
    localparam int HOLD    = 7;
    localparam int QUIET   = 10;
    localparam int WAKE    = 16;
    localparam logic [15:0] DEF = 16'h3100;

    logic               clk = 1'b0;
    logic               por_i = 1'b1;
    logic               hw_rst_n_i = 1'b1;
    logic [STRAP_W-1:0] strap_i = 8'hA5;
    logic               line_act_i = 1'b0;
    logic               mgmt_we_i = 1'b0;
    logic [4:0]         mgmt_addr_i = 5'h00;
    logic [15:0]        mgmt_wdata_i = 16'h0000;
    logic [15:0]        mgmt_rdata_o;
    logic               core_rst_o;
    logic [STRAP_W-1:0] strap_o;
    logic               pwr_down_o;
    logic               tx_wake_o;
    logic               mgmt_busy_o;

    always #2 clk = ~clk;

    phy_rst_ctrl #(
        .STRAP_W(STRAP_W), .HW_MIN_CYC(HW_MIN), .SW_RST_CYC(SW_RST),
        .HOLD_CYC(HOLD), .QUIET_CYC(QUIET), .WAKE_CYC(WAKE), .BASIC_DEFAULT(DEF)
    ) u_dut (.*);

    typedef struct {
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    logic rd_req = 1'b0;
    bit   done = 1'b0;

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        mgmt_we_i = 1'b1; mgmt_addr_i = a; mgmt_wdata_i = d;
        @(negedge clk);
        mgmt_we_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        mgmt_addr_i = a;
        rd_req = 1'b1;
        sb_q.push_back('{data: e, tag: tag});
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // monitor: pop expected read data and compare
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rd_req) begin
                exp_t e;
                if (sb_q.size() == 0) begin
                    check(1'b0, "scoreboard underflow", 32'(mgmt_rdata_o), 0);
                end else begin
                    e = sb_q.pop_front();
                    check(mgmt_rdata_o == e.data, e.tag, 32'(mgmt_rdata_o), 32'(e.data));
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int busy_n, core_n, seen, last, wakes;
        bit core_seen;

        // R1: power-on reset
        repeat (3) @(negedge clk);
        check(core_rst_o == 1'b1, "R1 core reset during por", 32'(core_rst_o), 1);
        por_i = 1'b0;
        @(negedge clk);
        check(core_rst_o == 1'b0, "R1 core reset released", 32'(core_rst_o), 0);
        check(strap_o == 8'hA5, "R1 straps latched", 32'(strap_o), 32'hA5);
        rd(5'h00, DEF, "R1 basic default");
        rd(5'h1D, 16'h0000, "R1 energy default");

        // R8: power-down bit
        wr(5'h00, DEF | 16'h0800);
        check(pwr_down_o == 1'b1, "R8 power-down bit", 32'(pwr_down_o), 1);
        rd(5'h00, DEF | 16'h0800, "R8 basic readback");

        // R2: short pin pulse ignored
        strap_i = 8'h3C;
        @(negedge clk); hw_rst_n_i = 1'b0;
        repeat (2) @(negedge clk); hw_rst_n_i = 1'b1;
        core_seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (core_rst_o) core_seen = 1'b1;
        end
        check(!core_seen, "R2 glitch gives no core reset", 32'(core_seen), 0);
        check(strap_o == 8'hA5, "R2 straps unchanged", 32'(strap_o), 32'hA5);
        rd(5'h00, DEF | 16'h0800, "R2 basic kept");

        // R3: qualified pin pulse
        @(negedge clk); hw_rst_n_i = 1'b0;
        repeat (12) @(negedge clk);
        check(core_rst_o == 1'b1, "R3 core reset on long pulse", 32'(core_rst_o), 1);
        hw_rst_n_i = 1'b1;
        repeat (8) @(negedge clk);
        check(core_rst_o == 1'b0, "R3 core reset released", 32'(core_rst_o), 0);
        check(strap_o == 8'h3C, "R3 straps resampled", 32'(strap_o), 32'h3C);
        rd(5'h00, DEF, "R3 basic default");

        // R4/R5/R7: command reset keeps straps
        wr(5'h00, DEF | 16'h0800);
        strap_i = 8'h77;
        wr(5'h00, 16'h8000);
        busy_n = 0; core_n = 0;
        for (int i = 0; i < 100 && mgmt_busy_o; i++) begin
            busy_n++;
            if (core_rst_o) core_n++;
            @(negedge clk);
        end
        check(busy_n == SW_RST + HOLD, "R4 busy length", 32'(busy_n), 32'(SW_RST + HOLD));
        check(core_n == SW_RST, "R4 core reset length", 32'(core_n), 32'(SW_RST));
        check(strap_o == 8'h3C, "R5 straps kept", 32'(strap_o), 32'h3C);
        check(pwr_down_o == 1'b0, "R5 power-down default", 32'(pwr_down_o), 0);
        rd(5'h00, DEF, "R7 self-clear and R5 default");

        // R6: access during busy
        wr(5'h00, 16'h8000);
        wr(5'h00, 16'h0800);
        rd(5'h00, 16'h0000, "R6 read zero while busy");
        for (int i = 0; i < 100 && mgmt_busy_o; i++) @(negedge clk);
        rd(5'h00, DEF, "R6 write dropped");
        check(pwr_down_o == 1'b0, "R6 no power-down", 32'(pwr_down_o), 0);

        // R11: unmapped address
        wr(5'h05, 16'hFFFF);
        rd(5'h05, 16'h0000, "R11 unmapped reads zero");
        rd(5'h00, DEF, "R11 basic untouched");
        rd(5'h1D, 16'h0000, "R11 energy untouched");

        // R9: energy-detect sleep and wake
        wr(5'h1D, 16'h0001);
        check(pwr_down_o == 1'b1, "R9 sleep when idle", 32'(pwr_down_o), 1);
        rd(5'h1D, 16'h0001, "R9 energy readback");
        @(negedge clk); line_act_i = 1'b1;
        @(negedge clk); line_act_i = 1'b0;
        check(pwr_down_o == 1'b0, "R9 awake on activity", 32'(pwr_down_o), 0);
        repeat (5) @(negedge clk);
        check(pwr_down_o == 1'b0, "R9 awake within quiet time", 32'(pwr_down_o), 0);
        repeat (15) @(negedge clk);
        check(pwr_down_o == 1'b1, "R9 back to sleep", 32'(pwr_down_o), 1);

        // R10: wake strobe spacing, independent of line activity
        seen = 0; last = -1; wakes = 0;
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            line_act_i = (i % 7 == 0);
            if (tx_wake_o) begin
                if (last >= 0)
                    check(i - last == WAKE, "R10 wake interval", 32'(i - last), 32'(WAKE));
                last = i;
                wakes++;
            end
        end
        line_act_i = 1'b0;
        check(wakes >= 4, "R10 wake pulses present", 32'(wakes), 4);
        wr(5'h1D, 16'h0000);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_wake_o) seen++;
        end
        check(seen == 0, "R10 no wake when disabled", 32'(seen), 0);

        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule